// File: doc/BRIEF.md
# Gated-Clock Cell Relocation Controller

This block moves the live state of one registered logic cell into a spare twin cell while the surrounding circuit keeps running. Both cells compute the same combinational function of the shared inputs. Both are clocked by the same function clock. The cell that currently holds the state loads only when the circuit's clock enable is high. A single start pulse launches a fixed sequence. The sequence first connects the spare's inputs. It then moves the state across through an auxiliary 2:1 multiplexer and an OR gate. Next it ties the spare's enable to the circuit enable and runs both cells side by side. Finally it hands the visible output to the spare and detaches the old cell, outputs first and inputs second.

The spare's data multiplexer is steered by the live clock enable. While the enable is low, the spare copies the source's stored value. While it is high, the spare loads the fresh function result together with the source. An enable edge that arrives in the middle of the transfer therefore leaves no stale copy behind. After a move the two cells swap roles, so a later start moves the state back. The visible output always equals a single clock-enabled register of the function result.

Top module: `reloc_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to idle (phase 0). `busy` and `done` go low, both cells clear to zero, and cell A becomes the live cell driving `cell_q`.
- R2: A `start` pulse is taken only in phase 0. A `start` seen in any other phase does not restart, lengthen or shorten the sequence.
- R3: Phase encoding is 0 idle, 1 connect, 2 transfer, 3 tie, 4 parallel, 5 output-detach, 6 input-detach. After an accepted start the order is 1 for one cycle, 2 for `XFER_CYCLES` cycles (at least 3), 3 for one cycle, 4 for `PAR_CYCLES` cycles (at least 2), 5 for one cycle, 6 for one cycle, then 0.
- R4: `busy` is high exactly while the phase is not 0.
- R5: `done` is a one-cycle pulse, high only in phase 6, where the old cell is released.
- R6: In phase 2 the spare cell loads on every edge. It takes the source cell's value when `ce` is low and the function input `func_d` when `ce` is high, so the two cells agree from the first transfer edge on.
- R7: In phases 4 and 5, `cell_a_q` and `cell_b_q` both equal the reference state.
- R8: `cell_q` always equals the reference state: a register cleared by reset that loads `func_d` on every edge where `ce` is high. No update is lost and the value does not change on an edge where `ce` is low.
- R9: Each completed sequence swaps the live and free cells. The free cell holds the value it had when released until the next transfer phase, and the live cell keeps tracking the reference state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to move the state to the free cell |
| ce | input | 1 | Circuit clock enable of the live cell |
| func_d | input | WIDTH | Combinational function result presented to the cells |
| cell_q | output | WIDTH | Visible registered output of the cell pair |
| cell_a_q | output | WIDTH | Stored value of cell A |
| cell_b_q | output | WIDTH | Stored value of cell B |
| phase | output | 3 | Current step of the sequence (encoding in R3) |
| busy | output | 1 | High while a relocation is in progress |
| done | output | 1 | Pulse marking release of the old cell |

## Verification
The relocation is exercised with `ce` held low through the whole sequence, which shows whether the spare takes a plain copy of the stored value. It is also run with `ce` held high, which shows whether the spare loads the fresh function result in lockstep with the source. Random `ce` toggles and random data are used to catch a lost or stale update when the enable changes state inside the transfer window. Back-to-back relocations show that the roles really swap and that the released cell stays frozen. Start pulses injected mid-sequence show that a running relocation cannot be disturbed.

// File: rtl/reloc_pkg.sv
// Shared types for the cell relocation controller.
// Assumes a 3-bit phase code; the numeric values are visible on the phase port.
package reloc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CONNECT = 3'd1,
        PH_XFER    = 3'd2,
        PH_TIE     = 3'd3,
        PH_PAR     = 3'd4,
        PH_DROPOUT = 3'd5,
        PH_DROPIN  = 3'd6
    } phase_e;

endpackage

// File: rtl/reloc_seq.sv
// Relocation sequencer: steps through the phases after an accepted start
// and decodes the control lines for the cell pair. Also holds which cell
// is live and swaps it when a move completes.
// Assumes XFER_CYCLES >= 3 and PAR_CYCLES >= 2.
module reloc_seq
    import reloc_pkg::*;
#(
    parameter int XFER_CYCLES = 3,
    parameter int PAR_CYCLES  = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   active,
    output logic   reloc_ctl,
    output logic   ce_ctl,
    output logic   inputs_par,
    output logic   dst_tie,
    output logic   src_live,
    output logic   out_dst,
    output logic   busy,
    output logic   done
);

    localparam int MAXC  = (XFER_CYCLES > PAR_CYCLES) ? XFER_CYCLES : PAR_CYCLES;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(XFER_CYCLES - 1);
    localparam logic [CNT_W-1:0] PAR_LAST  = CNT_W'(PAR_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Phase register, dwell counter and live-cell pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            active <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE:    if (start) phase <= PH_CONNECT;
                PH_CONNECT: begin
                    phase <= PH_XFER;
                    cnt   <= '0;
                end
                PH_XFER: begin
                    if (cnt == XFER_LAST) phase <= PH_TIE;
                    else                  cnt   <= cnt + 1'b1;
                end
                PH_TIE: begin
                    phase <= PH_PAR;
                    cnt   <= '0;
                end
                PH_PAR: begin
                    if (cnt == PAR_LAST) phase <= PH_DROPOUT;
                    else                 cnt   <= cnt + 1'b1;
                end
                PH_DROPOUT: phase <= PH_DROPIN;
                PH_DROPIN: begin
                    phase  <= PH_IDLE;
                    active <= ~active;
                end
                default:    phase <= PH_IDLE;
            endcase
        end
    end

    // Control decode from the current phase.
    always_comb begin
        reloc_ctl  = (phase == PH_XFER);
        ce_ctl     = (phase == PH_XFER);
        inputs_par = (phase != PH_IDLE);
        dst_tie    = (phase == PH_TIE) || (phase == PH_PAR) ||
                     (phase == PH_DROPOUT) || (phase == PH_DROPIN);
        src_live   = (phase != PH_DROPIN);
        out_dst    = (phase == PH_DROPOUT) || (phase == PH_DROPIN);
        busy       = (phase != PH_IDLE);
        done       = (phase == PH_DROPIN);
    end

endmodule

// File: rtl/reloc_ff.sv
// One registered logic cell with the auxiliary input multiplexer in front
// of its flip-flop. With pick_peer set the cell loads the peer's stored
// value, otherwise its own function result. Loads only when en is high.
module reloc_ff #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] func_d,
    input  logic [WIDTH-1:0] peer_q,
    input  logic             pick_peer,
    input  logic             en,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] d_sel;

    // Auxiliary 2:1 multiplexer.
    assign d_sel = pick_peer ? peer_q : func_d;

    // Enabled storage register.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d_sel;
    end

endmodule

// File: rtl/reloc_ctrl.sv
// Top of the relocation controller: two symmetric cells plus the sequencer.
// The live cell loads on ce. The free cell is steered by the sequence:
// during transfer its enable is ce OR the enable-control line and its mux
// is selected by ce; from tie onward it follows ce directly.
// Assumes func_d is the shared combinational result for both cells.
module reloc_ctrl
    import reloc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int XFER_CYCLES = 3,
    parameter int PAR_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ce,
    input  logic [WIDTH-1:0] func_d,
    output logic [WIDTH-1:0] cell_q,
    output logic [WIDTH-1:0] cell_a_q,
    output logic [WIDTH-1:0] cell_b_q,
    output logic [2:0]       phase,
    output logic             busy,
    output logic             done
);

    localparam int NCELL = 2;

    phase_e seq_phase;
    logic   active, reloc_ctl, ce_ctl, inputs_par, dst_tie, src_live, out_dst;
    logic [NCELL-1:0][WIDTH-1:0] q;

    reloc_seq #(
        .XFER_CYCLES(XFER_CYCLES),
        .PAR_CYCLES (PAR_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phase     (seq_phase),
        .active    (active),
        .reloc_ctl (reloc_ctl),
        .ce_ctl    (ce_ctl),
        .inputs_par(inputs_par),
        .dst_tie   (dst_tie),
        .src_live  (src_live),
        .out_dst   (out_dst),
        .busy      (busy),
        .done      (done)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        logic             is_src;
        logic [WIDTH-1:0] comb;
        logic             en;
        logic             pick;

        // Role of this cell: live source or free/destination.
        assign is_src = (active == 1'(i));
        // Inputs reach the free cell only once they are paralleled.
        assign comb   = (is_src || inputs_par) ? func_d : '0;
        // Enable: live cell on ce; free cell via OR gate or tied to ce.
        assign en     = is_src ? (src_live & ce)
                               : (dst_tie ? ce : (reloc_ctl & (ce | ce_ctl)));
        // Mux steered by the live enable while relocation control is on.
        assign pick   = !is_src && reloc_ctl && !ce;

        reloc_ff #(.WIDTH(WIDTH)) u_ff (
            .clk      (clk),
            .rst_n    (rst_n),
            .func_d   (comb),
            .peer_q   (q[NCELL-1-i]),
            .pick_peer(pick),
            .en       (en),
            .q        (q[i])
        );
    end

    // Visible output moves to the free cell once outputs are detached.
    assign cell_q   = q[active ^ out_dst];
    assign cell_a_q = q[0];
    assign cell_b_q = q[1];
    assign phase    = seq_phase;

endmodule

// File: rtl/reloc_chk.sv
// Property checker for reloc_ctrl, attached by bind below.
// Observes only the top-level ports.
module reloc_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ce,
    input logic [WIDTH-1:0] cell_q,
    input logic [WIDTH-1:0] cell_a_q,
    input logic [WIDTH-1:0] cell_b_q,
    input logic [2:0]       phase,
    input logic             busy,
    input logic             done
);

    // R1: reset forces idle with busy low.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (phase == 3'd0 && !busy && !done));

    // R2: a running sequence is never aborted by start.
    a_r2_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd0 && phase != 3'd6) |=> (phase != 3'd0));

    // R3: connect lasts one cycle and is followed by transfer.
    a_r3_connect_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |=> (phase == 3'd2));

    // R3: idle without start stays idle.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && !start) |=> (phase == 3'd0));

    // R4: busy only rises after a start request.
    a_r4_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R5: done lasts a single cycle.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: both cells agree while outputs are paralleled.
    a_r7_par_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4 || phase == 3'd5) |-> (cell_a_q == cell_b_q));

    // R8: the visible output holds on any edge with ce low.
    a_r8_hold_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(cell_q));

endmodule

bind reloc_ctrl reloc_chk #(.WIDTH(WIDTH)) u_reloc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ce      (ce),
    .cell_q  (cell_q),
    .cell_a_q(cell_a_q),
    .cell_b_q(cell_b_q),
    .phase   (phase),
    .busy    (busy),
    .done    (done)
);

// File: tb/reloc_ctrl_test.sv
// Bench for reloc_ctrl: behavioural reference model updated on each edge,
// all outputs compared every cycle at the falling edge.
module reloc_ctrl_test;

    localparam int W  = 4;
    localparam int XC = 3;
    localparam int PC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         ce = 1'b0;
    logic [W-1:0] func_d = '0;
    logic [W-1:0] cell_q, cell_a_q, cell_b_q;
    logic [2:0]   phase;
    logic         busy, done;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    int           m_ph;
    int           m_cnt;
    int           m_act;
    logic [W-1:0] m_ref;
    logic [W-1:0] m_free;

    always #5 clk = ~clk;

    reloc_ctrl #(.WIDTH(W), .XFER_CYCLES(XC), .PAR_CYCLES(PC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ce(ce), .func_d(func_d),
        .cell_q(cell_q), .cell_a_q(cell_a_q), .cell_b_q(cell_b_q),
        .phase(phase), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_cnt = 0; m_act = 0; m_ref = '0; m_free = '0;
    endtask

    task automatic model_edge(input bit st, input bit en, input logic [W-1:0] d);
        int old;
        old = m_ph;
        if (en) m_ref = d;
        case (old)
            0: if (st) m_ph = 1;
            1: begin m_ph = 2; m_cnt = 0; end
            2: if (m_cnt == XC-1) m_ph = 3; else m_cnt++;
            3: begin m_ph = 4; m_cnt = 0; end
            4: if (m_cnt == PC-1) m_ph = 5; else m_cnt++;
            5: begin m_ph = 6; m_free = m_ref; end
            6: begin m_ph = 0; m_act = 1 - m_act; end
            default: m_ph = 0;
        endcase
    endtask

    task automatic check_all();
        logic [W-1:0] src_q, dst_q;
        src_q = (m_act == 0) ? cell_a_q : cell_b_q;
        dst_q = (m_act == 0) ? cell_b_q : cell_a_q;
        chk(int'(phase) == m_ph, "R3 phase", int'(phase), m_ph);
        chk(busy == (m_ph != 0), "R4 busy", int'(busy), int'(m_ph != 0));
        chk(done == (m_ph == 6), "R5 done", int'(done), int'(m_ph == 6));
        chk(cell_q == m_ref, "R8 cell_q", int'(cell_q), int'(m_ref));
        if (m_ph <= 5) chk(src_q == m_ref, "R9 live cell", int'(src_q), int'(m_ref));
        if (m_ph >= 4) chk(dst_q == m_ref, "R7 replica", int'(dst_q), int'(m_ref));
        if (m_ph == 4 || m_ph == 5)
            chk(cell_a_q == cell_b_q, "R7 both equal", int'(cell_a_q), int'(cell_b_q));
        if (m_ph <= 1) chk(dst_q == m_free, "R9 free cell held", int'(dst_q), int'(m_free));
    endtask

    task automatic step(input bit st, input bit en, input logic [W-1:0] d);
        start = st; ce = en; func_d = d;
        @(posedge clk);
        model_edge(st, en, d);
        @(negedge clk);
        check_all();
    endtask

    // One relocation; ce_mode 0 low, 1 high, 2 random. Optional stray starts (R2).
    task automatic relocate(input int ce_mode, input bit stray);
        step(1'b1, (ce_mode == 1), W'($urandom));
        for (int k = 0; k < XC + PC + 5; k++) begin
            bit e;
            e = (ce_mode == 2) ? bit'($urandom % 2) : (ce_mode == 1);
            step(stray && (k % 2 == 0), e, W'($urandom));
        end
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        // R1: reset state, with activity on inputs.
        start = 1'b1; ce = 1'b1; func_d = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(phase == 3'd0, "R1 phase", int'(phase), 0);
        chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
        chk(cell_a_q == '0 && cell_b_q == '0, "R1 cells", int'({cell_a_q, cell_b_q}), 0);
        chk(cell_q == '0, "R1 cell_q", int'(cell_q), 0);
        rst_n = 1'b1; start = 1'b0;

        // R8: idle tracking with random enable.
        for (int k = 0; k < 12; k++) step(1'b0, bit'($urandom % 2), W'($urandom));
        // R6: copy with ce low throughout.
        step(1'b0, 1'b1, 4'hA);
        relocate(0, 1'b0);
        // R6: lockstep with ce high throughout.
        relocate(1, 1'b0);
        // R2: stray starts while busy, random ce.
        relocate(2, 1'b1);
        // R9: many back-to-back moves with random activity.
        for (int r = 0; r < 20; r++) begin
            for (int k = 0; k < int'($urandom % 4); k++)
                step(1'b0, bit'($urandom % 2), W'($urandom));
            relocate(2, bit'($urandom % 2));
        end
        // R1: reset in mid-sequence returns to idle with cell A live.
        step(1'b1, 1'b1, 4'h5);
        step(1'b0, 1'b1, 4'h6);
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        chk(phase == 3'd0 && !busy, "R1 mid reset", int'(phase), 0);
        chk(cell_q == '0, "R1 mid reset cell_q", int'(cell_q), 0);
        rst_n = 1'b1;
        relocate(2, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule